// File: doc/BRIEF.md
# Reorder Buffer Squash Walker

This block cancels the speculative tail of one thread's instruction window after a misprediction. The window itself lives outside the block as a circular queue per thread. For each thread the queue exposes a sequence number for every slot, plus the oldest slot, the youngest slot and the occupancy. When a squash request arrives with a thread and a boundary sequence number, the block starts at that thread's youngest slot and walks toward the oldest. It tags every entry whose sequence number is strictly greater than the boundary. Each tagged entry gets two sticky marks, squashed and ready-to-commit, so that it can drain through the normal commit path.

The walk is limited by bandwidth. It tags at most `WIDTH` entries per clock, so a deep squash takes several cycles. The walk ends in one of two ways: it meets an entry at or below the boundary, or it tags the thread's oldest entry. While a thread is being walked, its done flag is low and its insert-stall output is high. If the youngest entry of the thread was tagged, the block pulses a tail-update request so that downstream logic can recompute the tail.

Squash requests use a valid/ready handshake. A request transfers on a clock edge where both `sq_valid` and `sq_ready` are high. `sq_ready` is high exactly when no walk is in progress. The requester must hold `sq_valid`, `sq_tid` and `sq_bound` stable until the transfer. The queue view and `mark_clr` are plain level inputs. The queue view must stay stable while a walk is in progress, because inserts to the walked thread are stalled.

Top module: `rob_squash_walker`

## Requirements
- R1: After reset every done flag is 1, every insert-stall output is 0, no entry carries a mark, `sq_ready` is 1 and `tail_upd` is 0.
- R2: `sq_ready` is 1 only when no walk is in progress. A request transfers on an edge with `sq_valid` and `sq_ready` both high, and `sq_ready` is 0 from the next cycle until the walk finishes.
- R3: A request for a thread whose occupancy is 0 transfers, marks nothing, starts no walk, and leaves that thread's done flag at 1.
- R4: A request for a non-empty thread latches the boundary, clears that thread's done flag and raises its insert-stall output in the next cycle. The walk begins at that thread's youngest slot.
- R5: In each walk cycle at most `WIDTH` entries become marked. They are consecutive slots stepping toward the oldest entry, and each has a sequence number strictly greater than the boundary (unsigned compare).
- R6: Every tagged entry gets both its squashed mark and its ready-to-commit mark in the same cycle. The two marks of a slot are always equal.
- R7: When the walk tags the thread's oldest entry, the done flag is set in that same cycle.
- R8: After a cycle's batch of `WIDTH` tags, if the next slot to visit holds a sequence number at or below the boundary, the done flag is set in that same cycle.
- R9: If the slot under the walk pointer at the start of a cycle is at or below the boundary, the walk ends in that cycle and tags nothing.
- R10: If the thread's youngest entry was tagged, `tail_upd` is high for exactly one cycle and `tail_upd_tid` gives the thread. Otherwise no pulse is raised.
- R11: The walk pointer steps from slot 0 to slot `DEPTH-1`, so queues whose oldest slot index is above the youngest are walked correctly.
- R12: A walk changes neither the marks nor the done flag of any other thread.
- R13: A 1 in `mark_clr` clears both marks of that slot on the next edge. Flat slot index is thread*`DEPTH`+slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sq_valid | input | 1 | Squash request valid |
| sq_ready | output | 1 | High when no walk is in progress |
| sq_tid | input | TIDW | Thread of the squash request |
| sq_bound | input | SEQW | Boundary; entries with a greater sequence number are squashed |
| q_seq | input | NTHR*DEPTH*SEQW | Slot sequence numbers; slot s of thread t at bits [(t*DEPTH+s)*SEQW +: SEQW] |
| q_head | input | NTHR*IDXW | Oldest slot index per thread, field t at [t*IDXW +: IDXW] |
| q_tail | input | NTHR*IDXW | Youngest slot index per thread, field t at [t*IDXW +: IDXW] |
| q_count | input | NTHR*CNTW | Occupancy per thread, field t at [t*CNTW +: CNTW] |
| mark_clr | input | NTHR*DEPTH | Per-slot clear of both marks |
| ent_squashed | output | NTHR*DEPTH | Squashed mark per slot |
| ent_can_commit | output | NTHR*DEPTH | Ready-to-commit mark per slot |
| thr_done | output | NTHR | Squashing-done flag per thread |
| thr_insert_stall | output | NTHR | Insert stall per thread, high while that thread is walked |
| tail_upd | output | 1 | One-cycle tail-update request |
| tail_upd_tid | output | TIDW | Thread of the tail-update request |

## Verification
The cases that are hardest to reach from the ports are the two ways a walk can end exactly on a batch edge. In one, the batch of `WIDTH` tags is followed by a slot that equals the boundary, so the lookahead must finish the walk without an extra idle cycle. In the other, the oldest entry is reached in a queue whose oldest slot index lies above the youngest, so the pointer must wrap. Directed cases build these queues explicitly. The directed cases place the boundary equal to an entry a whole batch away from the tail, fill the queue with its oldest slot past index 0, and also cover an empty thread and a boundary above the youngest entry. Random cases then vary occupancy, head position, sequence gaps and boundary. Each walk is compared against a bench model for tagged slots, walk length and the tail pulse.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  typedef enum logic [0:0] {
    RSW_IDLE = 1'b0,
    RSW_WALK = 1'b1
  } rsw_state_e;

  // position `step` slots older than `pos` in a ring of `depth` slots
  function automatic int ring_back(int pos, int step, int depth);
    int r;
    r = (pos - step) % depth;
    if (r < 0) r = r + depth;
    return r;
  endfunction
endpackage

// File: rtl/rsw_window.sv
module rsw_window #(
  parameter int DEPTH = 8,
  parameter int SEQW  = 16,
  parameter int WIDTH = 3,
  parameter int IDXW  = 3
) (
  input  logic [DEPTH*SEQW-1:0] row_seq,
  input  logic [IDXW-1:0]       ptr,
  input  logic [IDXW-1:0]       head,
  input  logic [SEQW-1:0]       bound,
  input  logic                  active,
  output logic [DEPTH-1:0]      hit_slots,
  output logic                  finish,
  output logic [IDXW-1:0]       ptr_next
);
  import rsw_pkg::*;

  // WIDTH tagging taps plus one lookahead tap
  localparam int TAPS = WIDTH + 1;

  logic [IDXW-1:0] tap_idx [TAPS];
  logic [TAPS-1:0] tap_gt;
  logic [TAPS-1:0] tap_head;
  logic            chain_live;

  genvar k;
  generate
    for (k = 0; k < TAPS; k++) begin : g_tap
      assign tap_idx[k]  = IDXW'(ring_back(int'(ptr), k, DEPTH));
      assign tap_gt[k]   = row_seq[int'(tap_idx[k])*SEQW +: SEQW] > bound;
      assign tap_head[k] = (tap_idx[k] == head);
    end
  endgenerate

  always_comb begin
    chain_live = active;
    hit_slots  = '0;
    finish     = 1'b0;
    ptr_next   = ptr;
    for (int i = 0; i < TAPS; i++) begin
      if (chain_live) begin
        if (!tap_gt[i]) begin
          finish     = 1'b1;
          chain_live = 1'b0;
        end else if (i < WIDTH) begin
          hit_slots[tap_idx[i]] = 1'b1;
          ptr_next = tap_idx[i+1];
          if (tap_head[i]) begin
            finish     = 1'b1;
            chain_live = 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rsw_marks.sv
module rsw_marks #(
  parameter int NTHR  = 2,
  parameter int DEPTH = 8,
  parameter int WIDTH = 3,
  parameter int TIDW  = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_en,
  input  logic [TIDW-1:0]       set_tid,
  input  logic [DEPTH-1:0]      set_slots,
  input  logic [NTHR*DEPTH-1:0] clr,
  output logic [NTHR*DEPTH-1:0] squashed,
  output logic [NTHR*DEPTH-1:0] can_commit
);
  genvar t;
  generate
    for (t = 0; t < NTHR; t++) begin : g_thr
      logic [DEPTH-1:0] set_row;
      assign set_row = (set_en && (int'(set_tid) == t)) ? set_slots : '0;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          squashed[t*DEPTH +: DEPTH]   <= '0;
          can_commit[t*DEPTH +: DEPTH] <= '0;
        end else begin
          squashed[t*DEPTH +: DEPTH] <=
            (squashed[t*DEPTH +: DEPTH] & ~clr[t*DEPTH +: DEPTH]) | set_row;
          can_commit[t*DEPTH +: DEPTH] <=
            (can_commit[t*DEPTH +: DEPTH] & ~clr[t*DEPTH +: DEPTH]) | set_row;
        end
      end
    end
  endgenerate

  p_batch_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> ($countones(set_slots) <= WIDTH));

  p_mark_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    squashed == can_commit);
endmodule

// File: rtl/rob_squash_walker.sv
module rob_squash_walker #(
  parameter int NTHR  = 2,
  parameter int DEPTH = 8,
  parameter int SEQW  = 16,
  parameter int WIDTH = 3,
  parameter int TIDW  = (NTHR > 1) ? $clog2(NTHR) : 1,
  parameter int IDXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sq_valid,
  output logic                       sq_ready,
  input  logic [TIDW-1:0]            sq_tid,
  input  logic [SEQW-1:0]            sq_bound,
  input  logic [NTHR*DEPTH*SEQW-1:0] q_seq,
  input  logic [NTHR*IDXW-1:0]       q_head,
  input  logic [NTHR*IDXW-1:0]       q_tail,
  input  logic [NTHR*CNTW-1:0]       q_count,
  input  logic [NTHR*DEPTH-1:0]      mark_clr,
  output logic [NTHR*DEPTH-1:0]      ent_squashed,
  output logic [NTHR*DEPTH-1:0]      ent_can_commit,
  output logic [NTHR-1:0]            thr_done,
  output logic [NTHR-1:0]            thr_insert_stall,
  output logic                       tail_upd,
  output logic [TIDW-1:0]            tail_upd_tid
);
  import rsw_pkg::*;

  localparam int ROWW = DEPTH * SEQW;

  rsw_state_e       state_q;
  logic [TIDW-1:0]  cur_tid;
  logic [IDXW-1:0]  cur_ptr;
  logic [SEQW-1:0]  bound_q;
  logic [NTHR-1:0]  done_q;
  logic             tail_upd_q;
  logic [TIDW-1:0]  tail_tid_q;

  logic             accept;
  logic             req_nonempty;
  logic [IDXW-1:0]  req_tail;
  logic [ROWW-1:0]  cur_row;
  logic [IDXW-1:0]  cur_head;
  logic [IDXW-1:0]  cur_tail;
  logic             walking;
  logic [DEPTH-1:0] win_hit;
  logic             win_finish;
  logic [IDXW-1:0]  win_ptr_next;

  assign walking      = (state_q == RSW_WALK);
  assign sq_ready     = !walking;
  assign accept       = sq_valid && sq_ready;
  assign req_nonempty = (q_count[int'(sq_tid)*CNTW +: CNTW] != '0);
  assign req_tail     = q_tail[int'(sq_tid)*IDXW +: IDXW];
  assign cur_row      = q_seq[int'(cur_tid)*ROWW +: ROWW];
  assign cur_head     = q_head[int'(cur_tid)*IDXW +: IDXW];
  assign cur_tail     = q_tail[int'(cur_tid)*IDXW +: IDXW];

  rsw_window #(.DEPTH(DEPTH), .SEQW(SEQW), .WIDTH(WIDTH), .IDXW(IDXW)) u_window (
    .row_seq  (cur_row),
    .ptr      (cur_ptr),
    .head     (cur_head),
    .bound    (bound_q),
    .active   (walking),
    .hit_slots(win_hit),
    .finish   (win_finish),
    .ptr_next (win_ptr_next)
  );

  rsw_marks #(.NTHR(NTHR), .DEPTH(DEPTH), .WIDTH(WIDTH), .TIDW(TIDW)) u_marks (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (walking),
    .set_tid   (cur_tid),
    .set_slots (win_hit),
    .clr       (mark_clr),
    .squashed  (ent_squashed),
    .can_commit(ent_can_commit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= RSW_IDLE;
      cur_tid    <= '0;
      cur_ptr    <= '0;
      bound_q    <= '0;
      done_q     <= '1;
      tail_upd_q <= 1'b0;
      tail_tid_q <= '0;
    end else begin
      tail_upd_q <= 1'b0;
      if (!walking) begin
        if (accept && req_nonempty) begin
          state_q         <= RSW_WALK;
          cur_tid         <= sq_tid;
          cur_ptr         <= req_tail;
          bound_q         <= sq_bound;
          done_q[sq_tid]  <= 1'b0;
        end
      end else begin
        cur_ptr <= win_ptr_next;
        if (win_hit[cur_tail]) begin
          tail_upd_q <= 1'b1;
          tail_tid_q <= cur_tid;
        end
        if (win_finish) begin
          done_q[cur_tid] <= 1'b1;
          state_q         <= RSW_IDLE;
        end
      end
    end
  end

  assign thr_done         = done_q;
  assign thr_insert_stall = ~done_q;
  assign tail_upd         = tail_upd_q;
  assign tail_upd_tid     = tail_tid_q;

  p_accept_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_nonempty) |=> (!sq_ready && !thr_done[cur_tid]));

  p_empty_noop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_nonempty) |=> (sq_ready && $stable(thr_done)));

  p_busy_not_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_ready |-> !thr_done[cur_tid]);

  p_idle_done_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_ready && !sq_valid) |=> $stable(thr_done));

  p_tail_pulse_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tail_upd |=> !tail_upd);
endmodule

// File: tb/test_rob_squash_walker.sv
`timescale 1ns/1ps
module test_rob_squash_walker;
  localparam int NTHR = 2, DEPTH = 8, SEQW = 16, WIDTH = 3;
  localparam int TIDW = 1, IDXW = 3, CNTW = 4;

  logic clk = 0, rst_n = 0;
  logic sq_valid = 0, sq_ready;
  logic [TIDW-1:0] sq_tid = '0;
  logic [SEQW-1:0] sq_bound = '0;
  logic [NTHR*DEPTH*SEQW-1:0] q_seq = '0;
  logic [NTHR*IDXW-1:0] q_head = '0, q_tail = '0;
  logic [NTHR*CNTW-1:0] q_count = '0;
  logic [NTHR*DEPTH-1:0] mark_clr = '0, ent_squashed, ent_can_commit;
  logic [NTHR-1:0] thr_done, thr_insert_stall;
  logic tail_upd;
  logic [TIDW-1:0] tail_upd_tid;

  int tests = 0, fails = 0;
  int m_seq [NTHR][DEPTH];
  int m_head [NTHR];
  int m_cnt [NTHR];
  logic [NTHR*DEPTH-1:0] exp_marks = '0;

  always #5 clk = ~clk;

  rob_squash_walker #(.NTHR(NTHR), .DEPTH(DEPTH), .SEQW(SEQW), .WIDTH(WIDTH))
    i_rob_squash_walker (.*);

  task automatic chk(string req, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int tail_of(int t);
    return (m_head[t] + m_cnt[t] + DEPTH - 1) % DEPTH;
  endfunction

  task automatic publish();
    for (int t = 0; t < NTHR; t++) begin
      for (int s = 0; s < DEPTH; s++)
        q_seq[(t*DEPTH+s)*SEQW +: SEQW] = SEQW'(m_seq[t][s]);
      q_head[t*IDXW +: IDXW]  = IDXW'(m_head[t]);
      q_tail[t*IDXW +: IDXW]  = IDXW'(tail_of(t));
      q_count[t*CNTW +: CNTW] = CNTW'(m_cnt[t]);
    end
  endtask

  // fill thread t: oldest at head, increasing sequence numbers toward the tail
  task automatic fill(int t, int head, int cnt, int base, int maxgap);
    int v = base;
    m_head[t] = head; m_cnt[t] = cnt;
    for (int s = 0; s < DEPTH; s++) m_seq[t][s] = 0;
    for (int i = 0; i < cnt; i++) begin
      m_seq[t][(head + i) % DEPTH] = v;
      v = v + 1 + int'($urandom_range(maxgap - 1));
    end
  endtask

  // model of the walk: tagged slots, cycles to done, youngest tagged
  task automatic model(int t, int b, output logic [DEPTH-1:0] mk,
                       output int cyc, output bit th);
    int p = tail_of(t);
    bit fin = 0;
    mk = '0; cyc = 0; th = 0;
    while (!fin) begin
      int n = 0;
      cyc++;
      while (n < WIDTH && !fin) begin
        if (m_seq[t][p] <= b) fin = 1;
        else begin
          mk[p] = 1'b1;
          if (p == tail_of(t)) th = 1;
          if (p == m_head[t]) fin = 1;
          else begin p = (p + DEPTH - 1) % DEPTH; n++; end
        end
      end
      if (!fin && m_seq[t][p] <= b) fin = 1;
    end
  endtask

  task automatic clear_all();
    @(negedge clk); mark_clr = '1;
    @(negedge clk); mark_clr = '0;
    exp_marks = '0;
  endtask

  task automatic run_case(int t, int b);
    logic [DEPTH-1:0] mk;
    int ecyc, cyc, pulses, pulse_cyc, maxnew;
    bit th;
    logic [NTHR*DEPTH-1:0] prev;
    logic [NTHR-1:0] done_before;
    publish();
    done_before = thr_done;
    if (m_cnt[t] == 0) begin mk = '0; ecyc = 0; th = 0; end
    else model(t, b, mk, ecyc, th);
    @(negedge clk);
    chk("R2", "ready before request", sq_ready, 1);
    sq_valid = 1; sq_tid = TIDW'(t); sq_bound = SEQW'(b);
    @(negedge clk);
    sq_valid = 0;
    if (m_cnt[t] == 0) begin
      chk("R3", "ready after empty request", sq_ready, 1);
      chk("R3", "done vector after empty request", thr_done, done_before);
      chk("R3", "marks after empty request", ent_squashed, exp_marks);
      return;
    end
    chk("R4", "done cleared", thr_done[t], 0);
    chk("R4", "insert stall", thr_insert_stall[t], 1);
    chk("R2", "ready low while walking", sq_ready, 0);
    chk("R12", "other thread done", thr_done[1-t], done_before[1-t]);
    cyc = 0; pulses = 0; pulse_cyc = 0; maxnew = 0; prev = ent_squashed;
    while (thr_done[t] !== 1'b1 && cyc < 40) begin
      @(negedge clk); cyc++;
      if ($countones(ent_squashed & ~prev) > maxnew) maxnew = $countones(ent_squashed & ~prev);
      prev = ent_squashed;
      if (tail_upd) begin
        pulses++; pulse_cyc = cyc;
        chk("R10", "tail pulse thread", tail_upd_tid, t);
      end
    end
    @(negedge clk);
    if (tail_upd) pulses++;
    exp_marks[t*DEPTH +: DEPTH] = exp_marks[t*DEPTH +: DEPTH] | mk;
    chk("R8", "walk cycles", cyc, ecyc);
    chk("R5", "squashed marks", ent_squashed, exp_marks);
    chk("R6", "commit marks", ent_can_commit, exp_marks);
    chk("R5", "max tags per cycle within width", maxnew <= WIDTH, 1);
    chk("R10", "tail pulse count", pulses, th ? 1 : 0);
    if (th) chk("R10", "tail pulse cycle", pulse_cyc, 1);
    chk("R2", "ready after walk", sq_ready, 1);
    chk("R4", "stall released", thr_insert_stall[t], 0);
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = int'($urandom(32'd4711));
    for (int t = 0; t < NTHR; t++) fill(t, 0, 0, 0, 1);
    publish();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "done after reset", thr_done, 2'b11);
    chk("R1", "stall after reset", thr_insert_stall, 0);
    chk("R1", "marks after reset", ent_squashed | ent_can_commit, 0);
    chk("R1", "ready after reset", sq_ready, 1);
    chk("R1", "tail pulse after reset", tail_upd, 0);

    // R3: empty thread
    run_case(1, 5);
    // R9: boundary above the youngest entry
    fill(0, 2, 5, 100, 2); run_case(0, 200);
    // R9: boundary equal to the youngest entry
    run_case(0, m_seq[0][tail_of(0)]);
    // R7 R11: full queue with wrap, everything squashed
    clear_all(); fill(0, 5, 8, 40, 3); run_case(0, 0);
    // R8: boundary equal to the entry one batch behind the tail
    clear_all(); fill(0, 0, 6, 10, 1); run_case(0, 12);
    // R7: single entry queue
    clear_all(); fill(1, 7, 1, 300, 1); run_case(1, 299);
    // R12: thread 1 fully squashed, then thread 0 walk leaves it alone
    clear_all(); fill(1, 3, 6, 500, 2); run_case(1, 0);
    fill(0, 1, 7, 60, 2); run_case(0, m_seq[0][(1 + 3) % DEPTH]);
    // R13: clear one slot of thread 1
    @(negedge clk); mark_clr = '0; mark_clr[DEPTH + 4] = 1'b1;
    @(negedge clk); mark_clr = '0;
    exp_marks[DEPTH + 4] = 1'b0;
    chk("R13", "squashed after slot clear", ent_squashed, exp_marks);
    chk("R13", "commit after slot clear", ent_can_commit, exp_marks);

    // random mix
    for (int n = 0; n < 60; n++) begin
      int t, hd, cn, lo, hi;
      t = int'($urandom_range(NTHR - 1));
      hd = int'($urandom_range(DEPTH - 1));
      cn = int'($urandom_range(DEPTH));
      clear_all();
      fill(t, hd, cn, 50 + int'($urandom_range(1000)), 3);
      lo = (cn == 0) ? 0 : m_seq[t][hd] - 3;
      hi = (cn == 0) ? 10 : m_seq[t][tail_of(t)] + 2;
      run_case(t, lo + int'($urandom_range(hi - lo)));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule